// File: doc/BRIEF.md
# Serial EEPROM Size-Probing Reader

This block is the master side of a three-wire serial EEPROM link with a select line. It does not need to know the address width of the attached device in advance. After a start pulse it selects the device and sends the read command. It then clocks in all-zero address bits one at a time until the device answers with a low "dummy" bit on its data line. The number of address bits sent gives the device size in words. The reader then shifts in one data word, releases the device and reports both values.

The four wires sit in one registered control field. Every clock pulse has a parameterised settle time before the rising edge, so the interface can meet slow device timing from a fast system clock. A size found by a successful probe is kept. Later requests reuse it: they send that many address bits and do not search for the dummy bit again. A probe that passes the configured word limit reports size zero, and nothing is kept.

Top module: `sprom_probe_reader`

## Requirements
- R1: After reset, ctrl_o, done_o, size_o and data_o are all zero and no size is stored.
- R2: ctrl_o bit 0 is the shift clock, bit 1 the chip select, bit 2 the serial data sent to the device, and bit 3 the last sampled device output. On the cycle after an accepted start, select is high, the clock is low, bit 3 is low and bit 2 carries the first command bit. The clock is never high while select is low.
- R3: The read command 3'b110 is sent first, most significant bit first, one bit per clock pulse.
- R4: Each clock pulse keeps the clock low for SETTLE_CYC+1 cycles with the data bit already valid, then high for HIGH_CYC cycles. The data bit does not change while the clock is high.
- R5: After the command, address bits of value 0 are sent. A size count starts at 1 and doubles with each address bit. Probing stops after the first address bit whose device output, sampled at the end of the high phase, is 0. The reported size is then 2 to the power of the number of address bits.
- R6: If the doubled count exceeds MAX_WORDS, the probe aborts: size 0 and data 0 are reported and no data bits are clocked. This applies even when the dummy bit arrives on that same address bit.
- R7: After the address, DATA_W bits are shifted in most significant bit first, each sampled at the end of its high phase.
- R8: At the end of a transaction, select drops and done_o is high for exactly one cycle. In that cycle size_o and data_o hold the results, and they keep those values until the next done.
- R9: A nonzero size is stored. Later reads send exactly that many address bits, ignore the device output during the address, and report the stored size. A failed probe stores nothing, and reset clears the stored size.
- R10: A start pulse during a transaction is ignored. A start pulse in the done cycle is accepted and begins a new transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one read, accepted when idle |
| sdo_i | input | 1 | Serial data from the device |
| ctrl_o | output | 4 | {device output sample, data to device, select, clock} |
| done_o | output | 1 | One-cycle completion strobe |
| size_o | output | $clog2(MAX_WORDS)+2 | Detected size in words, 0 on failure |
| data_o | output | DATA_W | Word read from address zero |

## Verification
Two events can fall on the same address bit: the size count passes the word limit, and the device drives its dummy zero. The bench models a device whose address is one bit wider than the limit allows. Its dummy zero therefore lands on the bit where the count first passes the limit. For that bit, the abort must win: size and data must be zero, the clock pulse count must stop after that bit, and no data phase may follow. A second device held high throughout must abort at the same bit count.

// File: rtl/sprom_pkg.sv
package sprom_pkg;
  localparam int OPC_W = 3;
  localparam logic [OPC_W-1:0] READ_OPC = 3'b110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_FIN
  } rd_state_t;

  typedef enum logic [1:0] {
    PH_IDLE, PH_SETL, PH_HIGH
  } phase_t;
endpackage

// File: rtl/sprom_bit_timer.sv
module sprom_bit_timer
  import sprom_pkg::*;
#(
  parameter int SETTLE_CYC = 500,
  parameter int HIGH_CYC   = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  output logic sk_o,
  output logic last_o
);
  localparam int LONGEST = (SETTLE_CYC > HIGH_CYC) ? SETTLE_CYC : HIGH_CYC;
  localparam int CNT_W   = $clog2(LONGEST + 1);

  phase_t           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      sk_q    <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: if (go_i) begin
          phase_q <= PH_SETL;
          cnt_q   <= '0;
        end
        PH_SETL: if (cnt_q == CNT_W'(SETTLE_CYC - 1)) begin
          phase_q <= PH_HIGH;
          cnt_q   <= '0;
          sk_q    <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        PH_HIGH: if (cnt_q == CNT_W'(HIGH_CYC - 1)) begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
          sk_q    <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign sk_o   = sk_q;
  assign last_o = (phase_q == PH_HIGH) && (cnt_q == CNT_W'(HIGH_CYC - 1));

  // A new bit may only be launched once the previous pulse has finished.
  assert_go_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
    go_i |-> phase_q == PH_IDLE);
  assert_high_only_in_high_R4: assert property (@(posedge clk) disable iff (rst)
    sk_q |-> phase_q == PH_HIGH);
endmodule

// File: rtl/sprom_size_cache.sv
module sprom_size_cache #(
  parameter int SIZE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              valid_o,
  output logic [SIZE_W-1:0] size_o
);
  logic              valid_q;
  logic [SIZE_W-1:0] size_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      size_q  <= '0;
    end else if (wr_i && (size_i != '0)) begin
      valid_q <= 1'b1;
      size_q  <= size_i;
    end
  end

  assign valid_o = valid_q;
  assign size_o  = size_q;

  assert_cache_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> size_q != '0);
endmodule

// File: rtl/sprom_probe_reader.sv
module sprom_probe_reader
  import sprom_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int MAX_WORDS  = 256,
  parameter int SETTLE_CYC = 500,
  parameter int HIGH_CYC   = 250
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start_i,
  input  logic                           sdo_i,
  output logic [3:0]                     ctrl_o,
  output logic                           done_o,
  output logic [$clog2(MAX_WORDS)+1:0]   size_o,
  output logic [DATA_W-1:0]              data_o
);
  localparam int SIZE_W = $clog2(MAX_WORDS) + 2;
  localparam int BIT_W  = $clog2(DATA_W + 1);

  rd_state_t         state_q;
  logic              cs_q, di_q, do_q, go_q, fail_q, use_cache_q, done_q;
  logic [OPC_W-1:0]  opc_sh_q;
  logic [BIT_W-1:0]  bit_cnt_q;
  logic [SIZE_W-1:0] acc_q, size_q;
  logic [DATA_W-1:0] shreg_q, data_q;

  logic              sk, last;
  logic              cache_valid, cache_wr;
  logic [SIZE_W-1:0] cache_size, acc_dbl;

  sprom_bit_timer #(.SETTLE_CYC(SETTLE_CYC), .HIGH_CYC(HIGH_CYC)) timer_i (
    .clk(clk), .rst(rst), .go_i(go_q), .sk_o(sk), .last_o(last));

  sprom_size_cache #(.SIZE_W(SIZE_W)) cache_i (
    .clk(clk), .rst(rst), .wr_i(cache_wr), .size_i(acc_q),
    .valid_o(cache_valid), .size_o(cache_size));

  assign acc_dbl  = acc_q << 1;
  assign cache_wr = (state_q == ST_FIN) && !fail_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cs_q        <= 1'b0;
      di_q        <= 1'b0;
      do_q        <= 1'b0;
      go_q        <= 1'b0;
      fail_q      <= 1'b0;
      use_cache_q <= 1'b0;
      done_q      <= 1'b0;
      opc_sh_q    <= '0;
      bit_cnt_q   <= '0;
      acc_q       <= '0;
      size_q      <= '0;
      shreg_q     <= '0;
      data_q      <= '0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      if (last) do_q <= sdo_i;
      case (state_q)
        ST_IDLE: if (start_i) begin
          cs_q        <= 1'b1;
          di_q        <= READ_OPC[OPC_W-1];
          do_q        <= 1'b0;
          opc_sh_q    <= READ_OPC << 1;
          go_q        <= 1'b1;
          bit_cnt_q   <= '0;
          acc_q       <= SIZE_W'(1);
          shreg_q     <= '0;
          fail_q      <= 1'b0;
          use_cache_q <= cache_valid;
          state_q     <= ST_OPC;
        end
        ST_OPC: if (last) begin
          go_q <= 1'b1;
          if (bit_cnt_q == BIT_W'(OPC_W - 1)) begin
            di_q    <= 1'b0;
            state_q <= ST_ADDR;
          end else begin
            di_q      <= opc_sh_q[OPC_W-1];
            opc_sh_q  <= opc_sh_q << 1;
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
        ST_ADDR: if (last) begin
          acc_q     <= acc_dbl;
          bit_cnt_q <= '0;
          if (use_cache_q) begin
            go_q <= 1'b1;
            if (acc_dbl == cache_size) state_q <= ST_DATA;
          end else if (acc_dbl > SIZE_W'(MAX_WORDS)) begin
            fail_q  <= 1'b1;
            state_q <= ST_FIN;
          end else begin
            go_q <= 1'b1;
            if (!sdo_i) state_q <= ST_DATA;
          end
        end
        ST_DATA: if (last) begin
          shreg_q <= {shreg_q[DATA_W-2:0], sdo_i};
          if (bit_cnt_q == BIT_W'(DATA_W - 1)) begin
            state_q <= ST_FIN;
          end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
            go_q      <= 1'b1;
          end
        end
        ST_FIN: begin
          cs_q    <= 1'b0;
          done_q  <= 1'b1;
          size_q  <= fail_q ? '0 : acc_q;
          data_q  <= fail_q ? '0 : shreg_q;
          fail_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ctrl_o = {do_q, di_q, cs_q, sk};
  assign done_o = done_q;
  assign size_o = size_q;
  assign data_o = data_q;

  assert_sk_needs_cs_R2: assert property (@(posedge clk) disable iff (rst)
    sk |-> cs_q);
  assert_di_steady_R4: assert property (@(posedge clk) disable iff (rst)
    (sk && $past(sk)) |-> $stable(di_q));
  assert_addr_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ADDR) |-> !di_q);
  assert_size_pow2_R5: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $countones(size_q) <= 1);
  assert_size_cap_R6: assert property (@(posedge clk) disable iff (rst)
    done_q |-> size_q <= SIZE_W'(MAX_WORDS));
  assert_fail_blank_R6: assert property (@(posedge clk) disable iff (rst)
    (done_q && size_q == '0) |-> data_q == '0);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  assert_done_deselect_R8: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !cs_q);
endmodule

// File: tb/sprom_probe_reader_tb.sv
module sprom_probe_reader_tb_top;
  localparam int SETTLE = 3;
  localparam int HIGHC  = 2;
  localparam int MAXW   = 256;
  localparam int SW     = $clog2(MAXW) + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mdo = 1'b1;
  logic [3:0] ctrl;
  logic done;
  logic [SW-1:0] size;
  logic [15:0] data;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  sprom_probe_reader #(.DATA_W(16), .MAX_WORDS(MAXW), .SETTLE_CYC(SETTLE),
                       .HIGH_CYC(HIGHC)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .sdo_i(mdo), .ctrl_o(ctrl),
    .done_o(done), .size_o(size), .data_o(data));

  // Device model, evaluated away from the active edge
  int          m_aw = 6;
  logic        m_stuck = 1'b0;
  logic [15:0] m_word = '0;
  int          bitn = 0, rises = 0, addr_ones = 0;
  logic [2:0]  opc_rx = '0;
  logic        sk_prev = 1'b0;

  always @(negedge clk) begin
    if (!ctrl[1]) begin
      bitn = 0;
      mdo  = 1'b1;
    end else if (ctrl[0] && !sk_prev) begin
      bitn++;
      rises++;
      if (bitn <= 3) opc_rx = {opc_rx[1:0], ctrl[2]};
      else if (bitn <= 3 + m_aw && ctrl[2]) addr_ones++;
      if (m_stuck)                mdo = 1'b1;
      else if (bitn < 3 + m_aw)   mdo = 1'b1;
      else if (bitn == 3 + m_aw)  mdo = 1'b0;
      else if (bitn <= 19 + m_aw) mdo = m_word[15 - (bitn - 4 - m_aw)];
      else                        mdo = 1'b1;
    end
    sk_prev = ctrl[0];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic        rst;
    logic [4:0]  aw;
    logic        stuck;
    logic [15:0] word;
    logic [9:0]  esize;
    logic [15:0] edata;
    logic [5:0]  erises;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b1, 5'd6,  1'b0, 16'hA55A, 10'd64,  16'hA55A, 6'd25}, // R5 R7
    '{1'b1, 5'd1,  1'b0, 16'h8001, 10'd2,   16'h8001, 6'd20}, // R5 smallest
    '{1'b1, 5'd8,  1'b0, 16'h1234, 10'd256, 16'h1234, 6'd27}, // R5 at limit
    '{1'b1, 5'd9,  1'b0, 16'h5A5A, 10'd0,   16'h0000, 6'd12}, // R6 coincident
    '{1'b1, 5'd15, 1'b1, 16'h0000, 10'd0,   16'h0000, 6'd12}, // R6 stuck high
    '{1'b0, 5'd4,  1'b0, 16'hBEEF, 10'd16,  16'hBEEF, 6'd23}, // R9 fail not kept
    '{1'b0, 5'd15, 1'b1, 16'h0000, 10'd16,  16'hFFFF, 6'd23}  // R9 cached width
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    bit seen;
    int lo_cnt, hi_cnt;
    logic [SW-1:0] held_size;

    do_reset();
    check(ctrl == 4'b0 && !done && size == '0 && data == '0, "R1",
          "reset outputs", {ctrl, size[3:0]}, 0);

    // Vector table
    for (int v = 0; v < 7; v++) begin
      if (VECS[v].rst) do_reset();
      m_aw = int'(VECS[v].aw); m_stuck = VECS[v].stuck; m_word = VECS[v].word;
      rises = 0; addr_ones = 0; opc_rx = '0;
      pulse_start();
      wait_done(seen);
      check(seen, "R8", "done seen", int'(seen), 1);
      check(size == SW'(VECS[v].esize), "R5/R6/R9 (R5 R6 R9)", "size",
            int'(size), int'(VECS[v].esize));
      check(data == VECS[v].edata, "R7", "data", int'(data), int'(VECS[v].edata));
      check(rises == int'(VECS[v].erises), "R6", "clock pulses",
            rises, int'(VECS[v].erises));
      check(opc_rx == 3'b110, "R3", "command bits", int'(opc_rx), 6);
      check(addr_ones == 0, "R5", "nonzero address bits", addr_ones, 0);
      check(!ctrl[1], "R8", "select low at done", int'(ctrl[1]), 0);
      @(negedge clk);
    end

    // Start state of the control field and pulse timing
    do_reset();
    m_aw = 3; m_stuck = 1'b0; m_word = 16'h0F0F;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(ctrl == 4'b0110, "R2", "control at start", int'(ctrl), 6);
    lo_cnt = 0;
    while (!ctrl[0] && lo_cnt < 100) begin lo_cnt++; @(negedge clk); end
    check(lo_cnt == SETTLE + 1, "R4", "low before rise", lo_cnt, SETTLE + 1);
    hi_cnt = 0;
    while (ctrl[0] && hi_cnt < 100) begin hi_cnt++; @(negedge clk); end
    check(hi_cnt == HIGHC, "R4", "high width", hi_cnt, HIGHC);
    lo_cnt = 0;
    while (!ctrl[0] && lo_cnt < 100) begin lo_cnt++; @(negedge clk); end
    check(lo_cnt == SETTLE + 1, "R4", "gap between pulses", lo_cnt, SETTLE + 1);

    // Extra start while busy is ignored (R10)
    pulse_start();
    wait_done(seen);
    check(seen && size == SW'(8) && data == 16'h0F0F, "R10", "busy start result",
          int'(data), 16'h0F0F);
    held_size = size;
    @(negedge clk);
    check(!done && size == held_size, "R8", "done one cycle, size held",
          int'(done), 0);
    seen = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (done || ctrl[1]) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, "R10", "no second transaction", int'(seen), 0);

    // Start in the done cycle is accepted (R10), cached width used (R9)
    m_word = 16'h3C3C; rises = 0;
    pulse_start();
    wait_done(seen);
    check(seen && data == 16'h3C3C, "R9", "cached read data", int'(data), 16'h3C3C);
    m_word = 16'hC001; rises = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(ctrl[1], "R10", "start in done cycle accepted", int'(ctrl[1]), 1);
    wait_done(seen);
    check(seen && data == 16'hC001 && size == SW'(8), "R10", "back-to-back data",
          int'(data), 16'hC001);

    // Reset clears the stored size: stuck device must now fail (R9, R1)
    do_reset();
    m_stuck = 1'b1; m_aw = 15;
    pulse_start();
    wait_done(seen);
    check(seen && size == '0, "R9", "stored size cleared by reset", int'(size), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule